// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges four reasons to reset a chip into one internal reset that is synchronous to the system clock. The four reasons are a power-good event, an active-low external reset pin, a timeout from a watchdog, and a slow-clock detector. Each reason holds the reset for its own length of time. Power-up holds the reset for a long fixed time so that the clock can settle. The pin is accepted only after it has been low for long enough. The watchdog and the clock detector hold the reset while they are active, and a short fixed tail follows once every source has gone quiet. The reset returns control registers to known values and saves no processor state.

The clock detector counts system clocks between pulses of a slow reference tick. If one tick period holds fewer clocks than a threshold, the system clock is declared too slow. Set the threshold to the tick period multiplied by the lowest legal clock frequency (10 kHz). A 2-bit cause code names the source of the most recent reset so that software can read it after the reset is released.

The sequencer is a four-state machine. Its states are `SEQ_POWERUP` (long hold), `SEQ_RUN` (reset released), `SEQ_HOLD` (a source is active) and `SEQ_STRETCH` (fixed tail). Its transitions are:
- **power release**: power-good rises, the block enters POWERUP, and the counter clears.
- **settle done**: POWERUP goes to RUN once the counter reaches its last value.
- **trigger**: RUN goes to HOLD, and the cause is recorded.
- **quiet**: HOLD goes to STRETCH once no source is active.
- **retrigger**: STRETCH goes back to HOLD, and the cause is recorded again.
- **tail done**: STRETCH goes to RUN.

Top module: `reset_sequencer`

## Requirements
- R1: While `pwr_good_i` is low, `rst_o` is 1 and `cause_o` is 2'b00 (power-up code), at once and without waiting for a clock edge.
- R2: After `pwr_good_i` rises, `rst_o` stays 1 for exactly 4096 clock cycles, counted from the release, and then drops to 0.
- R3: During the power-up hold, the pin, the watchdog and the clock detector are ignored. The hold length does not change and `cause_o` stays 2'b00.
- R4: A low pulse on `ext_rst_n_i` that is sampled on fewer than 6 consecutive clock edges causes no reset and leaves `cause_o` unchanged.
- R5: A low pulse on `ext_rst_n_i` that covers L ≥ 6 consecutive edges makes `rst_o` high for L−1 cycles and sets `cause_o` to 2'b01. The pin passes through a 2-stage synchroniser before the low count starts.
- R6: `wdog_expire_i` held high for W edges makes `rst_o` high for W+4 cycles and sets `cause_o` to 2'b10.
- R7: After a pin, watchdog or clock reset, `rst_o` is released exactly 4 cycles after the first edge at which no source is active.
- R8: The clock detector flags a slow clock at a `ref_tick_i` pulse when fewer than 16 clocks (the default threshold) have passed since the previous pulse. Ticks spaced 16 clocks apart trip it; ticks spaced 17 apart do not. A slow clock resets the block with `cause_o` = 2'b11.
- R9: A slow-clock reset is released once a tick period of at least the threshold has been seen, followed by the 4-cycle tail.
- R10: When several sources trigger on the same edge, the cause is chosen in this priority order: clock 2'b11, then watchdog 2'b10, then pin 2'b01.
- R11: `cause_o` keeps its value after the reset is released and through pulses that are ignored. It is overwritten only when the next reset is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good_i | input | 1 | Digital power-good; low clears the block asynchronously, and a rising edge starts the power-up hold |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdog_expire_i | input | 1 | Watchdog timeout request, synchronous, active high |
| ref_tick_i | input | 1 | Slow reference tick, one-cycle pulse synchronous to `clk` |
| rst_o | output | 1 | Internal reset, active high |
| cause_o | output | 2 | Most recent reset cause: 00 power-up, 01 pin, 10 watchdog, 11 slow clock |

## Verification
The assertions assume the following about the inputs. The watchdog request and the reference tick are already synchronous to `clk`. The tick is a single-cycle pulse. Power-good low is the only way the block's own state is cleared. The bench drives every input half a period away from the rising edge. It changes the tick spacing only on the cycle a tick fires, so that no period is cut short by accident. The pin is the one input the assertions allow to arrive at any time, and its pulse lengths are counted in edges sampled after the synchroniser.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        SEQ_POWERUP = 2'd0,
        SEQ_RUN     = 2'd1,
        SEQ_HOLD    = 2'd2,
        SEQ_STRETCH = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_POWER = 2'b00,
        CAUSE_PIN   = 2'b01,
        CAUSE_WDOG  = 2'b10,
        CAUSE_CLOCK = 2'b11
    } cause_e;

    // Fixed priority: slow clock, then watchdog, then pin.
    function automatic cause_e pick_cause(input logic clk_bad,
                                          input logic wd_hit,
                                          input logic pin_hit);
        cause_e c;
        if (clk_bad)
            c = CAUSE_CLOCK;
        else if (wd_hit)
            c = CAUSE_WDOG;
        else if (pin_hit)
            c = CAUSE_PIN;
        else
            c = CAUSE_POWER;
        return c;
    endfunction

endpackage

// File: rtl/rst_pin_qualifier.sv
module rst_pin_qualifier #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_req
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LOW_SAT = LW'(MIN_LOW);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_sync;
    logic [LW-1:0]          low_cnt;

    // Synchroniser chain, reset to the released (high) level.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_sync = sync_q[SYNC_STAGES-1];

    // Saturating count of consecutive low samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (pin_sync)
            low_cnt <= '0;
        else if (low_cnt != LOW_SAT)
            low_cnt <= low_cnt + 1'b1;
    end

    assign pin_req = (low_cnt == LOW_SAT);

    // R4: a request only exists while the synchronised pin was low.
    p_req_needs_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_req |-> !$past(pin_sync))
        else $error("pin request without low pin");

    // R5: a high synchronised pin withdraws the request on the next edge.
    p_high_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sync |=> !pin_req)
        else $error("pin request survived high pin");

endmodule

// File: rtl/clk_rate_monitor.sv
module clk_rate_monitor #(
    parameter int MIN_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic clk_slow
);
    localparam int CW = $clog2(MIN_CLKS + 1);
    localparam logic [CW-1:0] CNT_SAT = CW'(MIN_CLKS);

    logic [CW-1:0] per_cnt;

    // Counts clocks between ticks, saturating at the threshold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt  <= '0;
            clk_slow <= 1'b0;
        end else if (ref_tick) begin
            clk_slow <= (per_cnt < CNT_SAT);
            per_cnt  <= '0;
        end else if (per_cnt != CNT_SAT) begin
            per_cnt  <= per_cnt + 1'b1;
        end
    end

    // R8: the verdict changes only on a reference tick.
    p_verdict_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_slow) |-> $past(ref_tick))
        else $error("slow flag moved without tick");

    // R9: a tick after a full-length period clears the flag.
    p_full_period_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && per_cnt == CNT_SAT) |=> !clk_slow)
        else $error("slow flag kept after full period");

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rstseq_pkg::*;
#(
    parameter int POR_CYCLES     = 4096,
    parameter int STRETCH_CYCLES = 4
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       pin_req,
    input  logic       wdog_req,
    input  logic       clk_slow,
    output logic       rst_out,
    output logic [1:0] cause_out
);
    localparam int CNT_MAX = (POR_CYCLES > STRETCH_CYCLES) ? POR_CYCLES : STRETCH_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] STR_LAST = CNT_W'(STRETCH_CYCLES - 1);

    seq_state_e       state, nxt_state;
    cause_e           cause, nxt_cause;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             any_req;

    assign any_req = pin_req | wdog_req | clk_slow;

    // State register, shared counter and cause register.
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state <= SEQ_POWERUP;
            cnt   <= '0;
            cause <= CAUSE_POWER;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            cause <= nxt_cause;
        end
    end

    // Transitions: settle done, trigger, quiet, retrigger, tail done.
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_cause = cause;
        unique case (state)
            SEQ_POWERUP: begin
                if (cnt == POR_LAST) begin
                    nxt_state = SEQ_RUN;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            SEQ_RUN: begin
                if (any_req) begin
                    nxt_state = SEQ_HOLD;
                    nxt_cause = pick_cause(clk_slow, wdog_req, pin_req);
                end
            end
            SEQ_HOLD: begin
                if (!any_req) begin
                    nxt_state = SEQ_STRETCH;
                    nxt_cnt   = '0;
                end
            end
            SEQ_STRETCH: begin
                if (any_req) begin
                    nxt_state = SEQ_HOLD;
                    nxt_cause = pick_cause(clk_slow, wdog_req, pin_req);
                end else if (cnt == STR_LAST) begin
                    nxt_state = SEQ_RUN;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        rst_out   = (state != SEQ_RUN);
        cause_out = cause;
    end

    // R1: power low forces reset with the power-up code.
    always @(posedge clk) begin
        if (!pwr_good) begin
            p_power_low_r1: assert (rst_out && cause_out == 2'b00)
                else $error("power low without power-up reset");
        end
    end

    // R3: the power-up hold keeps the power-up code whatever else happens.
    p_powerup_code_r3: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == SEQ_POWERUP) |=> (cause_out == 2'b00))
        else $error("cause overwritten during power-up");

    // R6: an active source outside power-up keeps reset asserted next cycle.
    p_source_holds_r6: assert property (@(posedge clk) disable iff (!pwr_good)
        (any_req && state != SEQ_POWERUP) |=> rst_out)
        else $error("reset released while a source is active");

    // R7: release after a tail happens only with all sources quiet.
    p_release_quiet_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        ($fell(rst_out) && $past(state) == SEQ_STRETCH) |-> !$past(any_req))
        else $error("released with a source active");

    // R10: a slow clock on a trigger edge always wins the cause.
    p_clock_first_r10: assert property (@(posedge clk) disable iff (!pwr_good)
        ((state == SEQ_RUN || state == SEQ_STRETCH) && clk_slow) |=> (cause_out == 2'b11))
        else $error("slow clock lost priority");

    // R11: cause is steady while running with no source active.
    p_cause_kept_r11: assert property (@(posedge clk) disable iff (!pwr_good)
        (state == SEQ_RUN && !any_req) |=> $stable(cause_out))
        else $error("cause changed without a reset");

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
    parameter int POR_CYCLES        = 4096,
    parameter int PIN_MIN_LOW       = 6,
    parameter int PIN_SYNC_STAGES   = 2,
    parameter int STRETCH_CYCLES    = 4,
    parameter int MIN_CLKS_PER_TICK = 16
) (
    input  logic       clk,
    input  logic       pwr_good_i,
    input  logic       ext_rst_n_i,
    input  logic       wdog_expire_i,
    input  logic       ref_tick_i,
    output logic       rst_o,
    output logic [1:0] cause_o
);
    logic pin_req;
    logic clk_slow;

    rst_pin_qualifier #(
        .SYNC_STAGES (PIN_SYNC_STAGES),
        .MIN_LOW     (PIN_MIN_LOW)
    ) u_pin (
        .clk     (clk),
        .rst_n   (pwr_good_i),
        .pin_n   (ext_rst_n_i),
        .pin_req (pin_req)
    );

    clk_rate_monitor #(
        .MIN_CLKS (MIN_CLKS_PER_TICK)
    ) u_mon (
        .clk      (clk),
        .rst_n    (pwr_good_i),
        .ref_tick (ref_tick_i),
        .clk_slow (clk_slow)
    );

    rst_seq_fsm #(
        .POR_CYCLES     (POR_CYCLES),
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .pwr_good  (pwr_good_i),
        .pin_req   (pin_req),
        .wdog_req  (wdog_expire_i),
        .clk_slow  (clk_slow),
        .rst_out   (rst_o),
        .cause_out (cause_o)
    );

endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // kind: 0 pin pulse, 1 watchdog pulse, 2 pin pulse with watchdog joining at recognition
    localparam int V_KIND  [NV] = '{0, 0, 1, 0, 0, 1, 2};
    localparam int V_DUR   [NV] = '{5, 6, 1, 3, 10, 4, 12};
    localparam int V_LEN   [NV] = '{0, 5, 5, 0, 9, 8, 11};
    localparam int V_CAUSE [NV] = '{0, 1, 2, 2, 1, 2, 2};

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdog = 1'b0;
    logic       ref_tick = 1'b0;
    logic       rst;
    logic [1:0] cause;

    int checks = 0;
    int errors = 0;
    int tick_period = 32;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_sequencer u_reset_sequencer (
        .clk           (clk),
        .pwr_good_i    (pwr_good),
        .ext_rst_n_i   (ext_rst_n),
        .wdog_expire_i (wdog),
        .ref_tick_i    (ref_tick),
        .rst_o         (rst),
        .cause_o       (cause)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference tick: one pulse every tick_period clocks.
    initial begin
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            if (tcnt >= tick_period - 1) begin
                ref_tick = 1'b1;
                tcnt = 0;
            end else begin
                ref_tick = 1'b0;
                tcnt++;
            end
        end
    end

    // Change the tick spacing right after a tick so no period is shortened.
    task automatic set_period(input int p);
        do begin
            @(negedge clk);
            #1;
        end while (!ref_tick);
        tick_period = p;
    endtask

    task automatic run_vec(input int kind, input int dur, output int len);
        len = 0;
        @(negedge clk);
        if (kind == 1) wdog = 1'b1;
        else           ext_rst_n = 1'b0;
        for (int i = 0; i < dur + 30; i++) begin
            @(negedge clk);
            #1;
            if (rst) len++;
            if (kind == 2 && i == 7) wdog = 1'b1;
            if (i == dur - 1) begin
                ext_rst_n = 1'b1;
                wdog = 1'b0;
            end
        end
    endtask

    initial begin
        int len;
        // R1: reset state while power is low
        repeat (5) @(negedge clk);
        #1;
        check("R1 rst", int'(rst), 1);
        check("R1 cause", int'(cause), 0);

        // R2/R3: power-up hold length with watchdog activity inside it
        @(negedge clk);
        pwr_good = 1'b1;
        #1;
        len = 0;
        for (int i = 0; i < 4200; i++) begin
            if (rst) len++;
            if (i == 100) wdog = 1'b1;
            if (i == 200) wdog = 1'b0;
            @(negedge clk);
            #1;
        end
        check("R2 hold length", len, 4096);
        check("R3 cause", int'(cause), 0);
        check("R2 released", int'(rst), 0);

        // Vector table: pin and watchdog pulses (R4 R5 R6 R7 R10 R11)
        for (int v = 0; v < NV; v++) begin
            run_vec(V_KIND[v], V_DUR[v], len);
            if (V_KIND[v] == 1)
                check("R6/R7 length", len, V_LEN[v]);
            else if (V_KIND[v] == 2)
                check("R10 length", len, V_LEN[v]);
            else if (V_LEN[v] == 0)
                check("R4 ignored", len, V_LEN[v]);
            else
                check("R5/R7 length", len, V_LEN[v]);
            if (V_KIND[v] == 2)
                check("R10 cause", int'(cause), V_CAUSE[v]);
            else
                check("R11 cause", int'(cause), V_CAUSE[v]);
            check("R7 released", int'(rst), 0);
        end

        // R8 boundary: 17-clock tick spacing is fast enough
        set_period(17);
        len = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            #1;
            if (rst) len++;
        end
        check("R8 no trip at 17", len, 0);

        // R8: 16-clock spacing trips the detector
        set_period(16);
        repeat (60) @(negedge clk);
        #1;
        check("R8 rst", int'(rst), 1);
        check("R8 cause", int'(cause), 3);

        // R9: recovery once periods are long again
        set_period(32);
        repeat (80) @(negedge clk);
        #1;
        check("R9 released", int'(rst), 0);
        check("R11 cause kept", int'(cause), 3);

        // R1: power drop clears immediately
        @(negedge clk);
        pwr_good = 1'b0;
        #1;
        check("R1 drop rst", int'(rst), 1);
        check("R1 drop cause", int'(cause), 0);
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (4100) @(negedge clk);
        #1;
        check("R2 second release", int'(rst), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule